// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data in one direction at a time. Each direction owns a storage register. The A-to-B register takes its value from the A bus, and the B-to-A register takes its value from the B bus. A per-direction select decides what the driven side receives. It can be the live value on the opposite bus, or the value last captured into that direction's register. This lets one block either pass traffic straight through or replay a stored word.

Both ports are split into separate input, output and per-bit output-enable vectors, so the block can sit inside a synthesized chip. Pad-level tristate drivers combine them outside the block. An active-low enable and a direction input choose which port drives.

The data width is divided into a parameter-set number of lanes, and every lane has its own set of controls. With the default 18-bit width and two lanes, the block runs as two independent 9-bit halves. Setting the lane count to one gives a single 18-bit transceiver.

All storage runs on one system clock. Each lane has two capture strobes, one per direction. A strobe that is high at a rising clock edge stores the bus value into that direction's register.

Top module: `xcvr_bus_top`

## Requirements
- R1: While a lane's `oe_n` is 1, every bit of that lane in both `a_oe` and `b_oe` is 0, whatever `dir` is.
- R2: While a lane's `oe_n` is 0 and its `dir` is 1, every bit of that lane in `b_oe` is 1 and every bit in `a_oe` is 0.
- R3: While a lane's `oe_n` is 0 and its `dir` is 0, every bit of that lane in `a_oe` is 1 and every bit in `b_oe` is 0.
- R4: With a lane's `sel_ab` at 0 (live), that lane of `b_out` equals the same lane of `a_in` in the same cycle, with no clock delay.
- R5: With a lane's `sel_ab` at 1 (stored), that lane of `b_out` shows the A-to-B register. That register loads `a_in` at a rising `clk` edge where `cap_ab` is 1, and keeps its value at every other edge.
- R6: `sel_ba`, `cap_ba` and the B-to-A register set that lane of `a_out` from `b_in` in the same way: 0 selects live, 1 selects stored.
- R7: Capture takes place at every strobed edge regardless of `oe_n` and `dir`, including while both ports are disabled.
- R8: Lane k covers bits [k*LW +: LW] of every bus vector, where LW = W/LANES. Each lane's controls affect only its own bits.
- R9: A rising `clk` edge with `rst_n` at 0 clears both registers of every lane to zero. Reset takes priority over a capture strobe.
- R10: When a lane captures in the same cycle that it replays, the output shows the old stored value during that cycle and the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of both registers |
| oe_n | input | LANES | Active-low output enable, one bit per lane |
| dir | input | LANES | Direction per lane: 1 drives B from A, 0 drives A from B |
| sel_ab | input | LANES | B-side source: 0 live A bus, 1 stored A-to-B register |
| sel_ba | input | LANES | A-side source: 0 live B bus, 1 stored B-to-A register |
| cap_ab | input | LANES | Capture strobe loading A-bus data into the A-to-B register |
| cap_ba | input | LANES | Capture strobe loading B-bus data into the B-to-A register |
| a_in | input | W | Value present on the A bus |
| a_out | output | W | Data offered to the A bus |
| a_oe | output | W | Per-bit drive enable for the A bus |
| b_in | input | W | Value present on the B bus |
| b_out | output | W | Data offered to the B bus |
| b_oe | output | W | Per-bit drive enable for the B bus |

## Verification
Capture and registered replay can land in the same cycle. A strobe can load a register while that same register is feeding the driven port. The bench raises `cap_ab` while `sel_ab` is 1 and a new word is on `a_in`. It expects the old stored word during that cycle and the new word only in the cycle after the edge. It also strobes both directions in one cycle and confirms that each register keeps its own source. A bound property follows each strobed edge to the replayed output.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source select for one direction: live bus or stored register.
  function automatic logic [63:0] pick_src(input logic use_store,
                                           input logic [63:0] live,
                                           input logic [63:0] stored);
    return use_store ? stored : live;
  endfunction

  // Drive enable for one side of a lane.
  // drive_to_b = 1 asks for the B side, 0 asks for the A side.
  function automatic logic side_drives(input logic oe_n,
                                       input logic dir,
                                       input logic drive_to_b);
    return !oe_n && (dir == drive_to_b);
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [LW-1:0] d,
  output logic [LW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_n,
  input  logic          dir,
  input  logic          sel_ab,
  input  logic          sel_ba,
  input  logic          cap_ab,
  input  logic          cap_ba,
  input  logic [LW-1:0] a_in,
  input  logic [LW-1:0] b_in,
  output logic [LW-1:0] a_out,
  output logic [LW-1:0] b_out,
  output logic [LW-1:0] a_oe,
  output logic [LW-1:0] b_oe
);

  logic [LW-1:0] stored_ab;
  logic [LW-1:0] stored_ba;
  logic [63:0]   mux_ab;
  logic [63:0]   mux_ba;

  xcvr_store #(.LW(LW)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .cap(cap_ab), .d(a_in), .q(stored_ab)
  );

  xcvr_store #(.LW(LW)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .cap(cap_ba), .d(b_in), .q(stored_ba)
  );

  always_comb begin
    mux_ab = pick_src(sel_ab, 64'(a_in), 64'(stored_ab));
    mux_ba = pick_src(sel_ba, 64'(b_in), 64'(stored_ba));
    b_out  = mux_ab[LW-1:0];
    a_out  = mux_ba[LW-1:0];
    b_oe   = {LW{side_drives(oe_n, dir, 1'b1)}};
    a_oe   = {LW{side_drives(oe_n, dir, 1'b0)}};
  end

endmodule

// File: rtl/xcvr_bus_top.sv
module xcvr_bus_top #(
  parameter int W     = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [LANES-1:0] cap_ab,
  input  logic [LANES-1:0] cap_ba,
  input  logic [W-1:0]     a_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     a_oe,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     b_oe
);

  localparam int LW = W / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane #(.LW(LW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .oe_n  (oe_n[l]),
      .dir   (dir[l]),
      .sel_ab(sel_ab[l]),
      .sel_ba(sel_ba[l]),
      .cap_ab(cap_ab[l]),
      .cap_ba(cap_ba[l]),
      .a_in  (a_in[l*LW +: LW]),
      .b_in  (b_in[l*LW +: LW]),
      .a_out (a_out[l*LW +: LW]),
      .b_out (b_out[l*LW +: LW]),
      .a_oe  (a_oe[l*LW +: LW]),
      .b_oe  (b_oe[l*LW +: LW])
    );
  end

endmodule

// File: rtl/xcvr_bus_chk.sv
module xcvr_bus_chk #(
  parameter int W     = 18,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] oe_n,
  input logic [LANES-1:0] dir,
  input logic [LANES-1:0] sel_ab,
  input logic [LANES-1:0] sel_ba,
  input logic [LANES-1:0] cap_ab,
  input logic [LANES-1:0] cap_ba,
  input logic [W-1:0]     a_in,
  input logic [W-1:0]     a_out,
  input logic [W-1:0]     a_oe,
  input logic [W-1:0]     b_in,
  input logic [W-1:0]     b_out,
  input logic [W-1:0]     b_oe
);

  localparam int LW = W / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R1
    idle_no_drive_chk: assert property (@(posedge clk)
      oe_n[l] |-> (a_oe[l*LW +: LW] == '0 && b_oe[l*LW +: LW] == '0));

    // R2 R3
    one_side_drives_chk: assert property (@(posedge clk)
      !oe_n[l] |-> (dir[l] ? (b_oe[l*LW +: LW] == '1 && a_oe[l*LW +: LW] == '0)
                           : (a_oe[l*LW +: LW] == '1 && b_oe[l*LW +: LW] == '0)));

    // R4
    live_pass_chk: assert property (@(posedge clk)
      !sel_ab[l] |-> (b_out[l*LW +: LW] == a_in[l*LW +: LW]));

    // R5 R10
    capture_replay_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ab[l] |=> (sel_ab[l] ? (b_out[l*LW +: LW] == $past(a_in[l*LW +: LW])) : 1'b1));

    // R6
    capture_replay_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ba[l] |=> (sel_ba[l] ? (a_out[l*LW +: LW] == $past(b_in[l*LW +: LW])) : 1'b1));

    // R5
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_ab[l] && sel_ab[l]) |=> (sel_ab[l] ? $stable(b_out[l*LW +: LW]) : 1'b1));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> ((sel_ab[l] ? (b_out[l*LW +: LW] == '0) : 1'b1) &&
                  (sel_ba[l] ? (a_out[l*LW +: LW] == '0) : 1'b1)));
  end

endmodule

bind xcvr_bus_top xcvr_bus_chk #(.W(W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
  .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba), .a_in(a_in),
  .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/xcvr_bus_top_tb_top.sv
module xcvr_bus_top_tb_top;

  localparam int CLK_P = 10;
  localparam int W     = 18;
  localparam int LANES = 2;
  localparam int LW    = W / LANES;
  localparam int NVEC  = 12;

  // {oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba, a_in, b_in}; each control applies to both lanes
  localparam logic [41:0] VEC [NVEC] = '{
    {6'b100011, 18'h15555, 18'h2AAAA},  // R7 capture while disabled
    {6'b111100, 18'h3FFFF, 18'h00000},  // R1 stored values visible, nothing driven
    {6'b011000, 18'h12345, 18'h0F0F0},  // R2 B drives stored word
    {6'b010000, 18'h12345, 18'h0F0F0},  // R4 live pass to B
    {6'b000100, 18'h06789, 18'h3C3C3},  // R3 A drives stored word
    {6'b000000, 18'h06789, 18'h3C3C3},  // R6 live pass to A
    {6'b011010, 18'h00FF0, 18'h00000},  // R10 capture during replay
    {6'b011000, 18'h3000F, 18'h00000},  // R10 new word next cycle
    {6'b001111, 18'h11111, 18'h22222},  // R10 both strobes together
    {6'b001100, 18'h0ABCD, 18'h1DCBA},  // R5 R6 both registers replay
    {6'b110011, 18'h01234, 18'h04321},  // R7 capture with oe_n high
    {6'b011100, 18'h00000, 18'h3FFFF}   // R5 R6 replay after disabled capture
  };

  logic clk = 0;
  logic rst_n;
  logic [LANES-1:0] oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
  logic [W-1:0] m_ab, m_ba;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  always #(CLK_P/2) clk = ~clk;

  xcvr_bus_top #(.W(W), .LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check after settling, then advance the bench model at posedge.
  task automatic step(input logic rst, input logic [LANES-1:0] o, d, sab, sba, cab, cba,
                      input logic [W-1:0] a, b, input string tag);
    logic [W-1:0] e_aoe, e_boe, e_aout, e_bout;
    rst_n = rst; oe_n = o; dir = d; sel_ab = sab; sel_ba = sba;
    cap_ab = cab; cap_ba = cba; a_in = a; b_in = b;
    #1;
    for (int l = 0; l < LANES; l++) begin
      e_boe[l*LW +: LW]  = (!o[l] && d[l])  ? '1 : '0;
      e_aoe[l*LW +: LW]  = (!o[l] && !d[l]) ? '1 : '0;
      e_bout[l*LW +: LW] = sab[l] ? m_ab[l*LW +: LW] : a[l*LW +: LW];
      e_aout[l*LW +: LW] = sba[l] ? m_ba[l*LW +: LW] : b[l*LW +: LW];
    end
    check({tag, " R1/R2 b_oe"}, b_oe, e_boe);
    check({tag, " R1/R3 a_oe"}, a_oe, e_aoe);
    check({tag, " R4/R5 b_out"}, b_out, e_bout);
    check({tag, " R6 a_out"}, a_out, e_aout);
    @(posedge clk);
    for (int l = 0; l < LANES; l++) begin
      if (!rst) begin
        m_ab[l*LW +: LW] = '0;
        m_ba[l*LW +: LW] = '0;
      end else begin
        if (cab[l]) m_ab[l*LW +: LW] = a[l*LW +: LW];
        if (cba[l]) m_ba[l*LW +: LW] = b[l*LW +: LW];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    m_ab = 'x; m_ba = 'x;
    @(negedge clk);
    // R9 reset beats a strobe; live paths still work during reset
    step(1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 18'h1FFFF, 18'h2EEEE, "R9 in reset");
    // R9 registers read zero after reset
    step(1'b1, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 18'h3AAAA, 18'h05555, "R9 reset state");

    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] c;
      c = VEC[i][41:36];
      step(1'b1, {2{c[5]}}, {2{c[4]}}, {2{c[3]}}, {2{c[2]}}, {2{c[1]}}, {2{c[0]}},
           VEC[i][35:18], VEC[i][17:0], $sformatf("vec%0d", i));
    end

    // R8 lanes with opposite controls: lane0 drives B from storage, lane1 disabled and live
    step(1'b1, 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10, 18'h2B3C4, 18'h1A2B3, "R8 split");
    step(1'b1, 2'b01, 2'b10, 2'b01, 2'b10, 2'b00, 2'b00, 18'h00000, 18'h3FFFF, "R8 split replay");
    // R7 strobe only lane1 while disabled, then replay both lanes
    step(1'b1, 2'b11, 2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 18'h3FE00, 18'h00000, "R7 lane1 cap");
    step(1'b1, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 18'h00000, 18'h00000, "R8 lane1 only");
    // R9 mid-run reset clears stored words
    step(1'b0, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 18'h12121, 18'h21212, "R9 mid reset");
    step(1'b1, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 18'h3FFFF, 18'h3FFFF, "R9 after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule